// File: doc/BRIEF.md
# Double-Word Shift and Normalize Engine

This block operates on a 32-bit operand formed from two 16-bit halves, a high word (AC) and a low word (MQ). It performs one of three operations: a logical shift, an arithmetic shift, or a normalize. Shift operations take a 6-bit two's-complement count. Counts 1 to 31 shift left by that amount. Counts 32 to 63 shift right by 64 minus the count. The result is returned as new high and low words, a step count, and four flags: negative, overflow, carry, and a combined negative-xor-overflow bit.

A shift is a single combinational pass through a barrel network, and its result is registered one cycle after the start pulse. A normalize moves the operand left one bit per cycle. It stops when the high word's two top bits differ, when the operand reaches the special pattern high word 0xC000 with a zero low word, or when 31 positions have been moved. The number of positions moved is left in the step count. Every operation ends with a one-cycle `done` pulse. `busy` is high while a normalize is running.

Top module: `sne_engine`

## Requirements
- R1: After reset, `ac_out`, `mq_out`, `step_out`, all four flags, `busy` and `done` are zero.
- R2: A shift with count 0 returns the operand unchanged, with overflow and carry clear.
- R3: `op`=00 is a logical shift. For counts 1..31 all 32 bits move left and zeros enter at bit 0. Carry is the last bit pushed out of bit 31. Overflow is set when any pushed-out bit, or the original sign, differs from the new bit 31.
- R4: `op`=01 is an arithmetic shift. For counts 1..31 bit 31 is held and only bits 30:0 move left. Carry is the last bit pushed out of bit 30. Overflow is set when any pushed-out bit differs from the sign.
- R5: For counts 32..63 both shifts move right by 64 minus the count, so a count of 32 moves 32 places. The logical shift fills with zeros and the arithmetic shift fills with the sign. Carry is the last bit moved out of bit 0, and overflow is clear.
- R6: After a shift, `step_out` is zero, `flag_n` equals the result's bit 31, and `flag_nv` equals `flag_v` xor `flag_n`.
- R7: `op`=1x is a normalize, and `count` is ignored. The operand moves left one bit per cycle, bringing the low word's top bit into the high word. It stops when AC bit 15 differs from AC bit 14, when AC is 0xC000 and MQ is 0, or after 31 moves. `step_out` then holds the number of moves.
- R8: After a normalize, overflow and carry are clear, and `flag_n` and `flag_nv` both equal the result's bit 31.
- R9: A shift raises `done` in the cycle after its start. A normalize of k moves holds `busy` from the cycle after its start and raises `done`, with `busy` low, k+2 cycles after the start.
- R10: A `start` while `busy` is high is ignored. The running normalize completes as if that start had not occurred, and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on the inputs this cycle |
| op | input | 2 | 00 logical shift, 01 arithmetic shift, 1x normalize |
| count | input | 6 | Two's-complement shift count |
| ac_in | input | 16 | Operand high word |
| mq_in | input | 16 | Operand low word |
| ac_out | output | 16 | Result high word |
| mq_out | output | 16 | Result low word |
| step_out | output | 6 | Step count |
| flag_n | output | 1 | Result negative |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry, last bit shifted out |
| flag_nv | output | 1 | Negative xor overflow |
| busy | output | 1 | Normalize in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse of one operation and the acceptance of the next `start`.

The bench provokes this in two ways. It issues two shifts on consecutive cycles, and it places a shift start in the cycle where a normalize finishes. In both cases the scoreboard judges each result against its own due cycle and its own expected words and flags.

The opposite collision is also tested: a start arriving mid-normalize. It is judged by the absence of an extra completion and by the unchanged normalize result.

// File: rtl/sne_pkg.sv
package sne_pkg;

    typedef enum logic [1:0] {
        OP_LSH  = 2'b00,
        OP_ASH  = 2'b01,
        OP_NRM  = 2'b10,
        OP_NRM2 = 2'b11
    } sne_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_NORM = 1'b1
    } sne_state_e;

endpackage

// File: rtl/sne_barrel.sv
// Single-pass shifter for the double word: left for counts below half the
// count range, right by (2*DW - count) otherwise. Arithmetic mode pins the MSB.
module sne_barrel #(
    parameter int DW = 32,
    parameter int CW = $clog2(DW) + 1
) (
    input  logic          arith,
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] x,
    output logic [DW-1:0] res,
    output logic          v,
    output logic          c
);
    localparam int FW = 2 * DW;

    logic          sgn;
    logic [FW-1:0] sext;
    logic [FW-1:0] zext;
    logic [FW-1:0] sh_l;
    logic [FW-1:0] sh_r;
    logic [FW-1:0] sh_r1;
    logic [DW-1:0] lost;
    logic [CW:0]   rdist;
    logic [CW-2:0] ldist;

    always_comb begin
        sgn   = x[DW-1];
        sext  = {{DW{sgn}}, x};
        zext  = {{DW{1'b0}}, x};
        ldist = cnt[CW-2:0];
        rdist = (CW+1)'(FW) - {1'b0, cnt};
        sh_l  = sext << ldist;
        sh_r  = (arith ? sext : zext) >> rdist;
        sh_r1 = zext >> (rdist - (CW+1)'(1));
        res   = x;
        v     = 1'b0;
        c     = 1'b0;
        lost  = '0;
        if (cnt == '0) begin
            res = x;
        end else if (!cnt[CW-1]) begin
            if (arith) begin
                res  = {sgn, sh_l[DW-2:0]};
                lost = sh_l[FW-2:DW-1];
                c    = sh_l[DW-1];
                v    = (lost != {DW{sgn}});
            end else begin
                res  = sh_l[DW-1:0];
                lost = sh_l[FW-1:DW];
                c    = sh_l[DW];
                v    = (lost != {DW{sh_l[DW-1]}});
            end
        end else begin
            res = sh_r[DW-1:0];
            c   = sh_r1[0];
        end
    end
endmodule

// File: rtl/sne_norm_step.sv
// One normalize step: stop test on the current operand and the next value.
module sne_norm_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ac,
    input  logic [W-1:0] mq,
    output logic         stop,
    output logic [W-1:0] ac_nx,
    output logic [W-1:0] mq_nx
);
    localparam logic [W-1:0] SPECIAL = {2'b11, {(W-2){1'b0}}};

    always_comb begin
        stop  = (ac[W-1] ^ ac[W-2]) | ((ac == SPECIAL) & (mq == '0));
        ac_nx = {ac[W-2:0], mq[W-1]};
        mq_nx = {mq[W-2:0], 1'b0};
    end
endmodule

// File: rtl/sne_engine.sv
module sne_engine #(
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              op,
    input  logic [$clog2(2*W):0]    count,
    input  logic [W-1:0]            ac_in,
    input  logic [W-1:0]            mq_in,
    output logic [W-1:0]            ac_out,
    output logic [W-1:0]            mq_out,
    output logic [$clog2(2*W):0]    step_out,
    output logic                    flag_n,
    output logic                    flag_v,
    output logic                    flag_c,
    output logic                    flag_nv,
    output logic                    busy,
    output logic                    done
);
    import sne_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW) + 1;
    localparam logic [CW-1:0] SC_MAX = CW'(DW - 1);

    typedef struct packed {
        sne_state_e    st;
        logic [W-1:0]  ac;
        logic [W-1:0]  mq;
        logic [CW-1:0] sc;
        logic          n;
        logic          v;
        logic          c;
        logic          nv;
        logic          done;
    } eng_t;

    eng_t eng_d, eng_q;

    sne_op_e       op_e;
    logic [DW-1:0] bar_res;
    logic          bar_v;
    logic          bar_c;
    logic          nrm_stop;
    logic [W-1:0]  nrm_ac;
    logic [W-1:0]  nrm_mq;

    assign op_e = sne_op_e'(op);

    sne_barrel #(.DW(DW), .CW(CW)) u_barrel (
        .arith (op_e == OP_ASH),
        .cnt   (count),
        .x     ({ac_in, mq_in}),
        .res   (bar_res),
        .v     (bar_v),
        .c     (bar_c)
    );

    sne_norm_step #(.W(W)) u_norm (
        .ac    (eng_q.ac),
        .mq    (eng_q.mq),
        .stop  (nrm_stop),
        .ac_nx (nrm_ac),
        .mq_nx (nrm_mq)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (op_e == OP_NRM || op_e == OP_NRM2) begin
                        eng_d.st = ST_NORM;
                        eng_d.ac = ac_in;
                        eng_d.mq = mq_in;
                        eng_d.sc = '0;
                        eng_d.n  = 1'b0;
                        eng_d.v  = 1'b0;
                        eng_d.c  = 1'b0;
                        eng_d.nv = 1'b0;
                    end else begin
                        eng_d.ac   = bar_res[DW-1:W];
                        eng_d.mq   = bar_res[W-1:0];
                        eng_d.sc   = '0;
                        eng_d.n    = bar_res[DW-1];
                        eng_d.v    = bar_v;
                        eng_d.c    = bar_c;
                        eng_d.nv   = bar_v ^ bar_res[DW-1];
                        eng_d.done = 1'b1;
                    end
                end
            end
            ST_NORM: begin
                if (nrm_stop || eng_q.sc == SC_MAX) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.n    = eng_q.ac[W-1];
                    eng_d.nv   = eng_q.ac[W-1];
                    eng_d.v    = 1'b0;
                    eng_d.c    = 1'b0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.ac = nrm_ac;
                    eng_d.mq = nrm_mq;
                    eng_d.sc = eng_q.sc + CW'(1);
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign ac_out   = eng_q.ac;
    assign mq_out   = eng_q.mq;
    assign step_out = eng_q.sc;
    assign flag_n   = eng_q.n;
    assign flag_v   = eng_q.v;
    assign flag_c   = eng_q.c;
    assign flag_nv  = eng_q.nv;
    assign busy     = (eng_q.st == ST_NORM);
    assign done     = eng_q.done;

endmodule

// File: rtl/sne_checker.sv
module sne_checker #(
    parameter int W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [1:0]           op,
    input logic [$clog2(2*W):0] count,
    input logic [W-1:0]         ac_in,
    input logic [W-1:0]         mq_in,
    input logic [W-1:0]         ac_out,
    input logic [W-1:0]         mq_out,
    input logic [$clog2(2*W):0] step_out,
    input logic                 flag_n,
    input logic                 flag_v,
    input logic                 flag_c,
    input logic                 flag_nv,
    input logic                 busy,
    input logic                 done
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW) + 1;

    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op[1] && count == '0) |=>
        (ac_out == $past(ac_in) && mq_out == $past(mq_in) && !flag_v && !flag_c));

    a_r4_ash_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b01 && count != '0 && !count[CW-1]) |=>
        (ac_out[W-1] == $past(ac_in[W-1])));

    a_r5_lsh_half_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b00 && count == CW'(DW)) |=>
        (ac_out == '0 && mq_out == '0 && !flag_v));

    a_r6_shift_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op[1]) |=> (done && step_out == '0 && !busy));

    a_r6_flag_relation: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_nv == (flag_v ^ flag_n) && flag_n == ac_out[W-1]));

    a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_out < CW'(DW)));

    a_r8_norm_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !flag_v && !flag_c && flag_n == ac_out[W-1]));

    a_r9_norm_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op[1]) |=> (busy && !done && step_out == '0));

    a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start && !busy) || $past(busy)));

endmodule

bind sne_engine sne_checker #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .count    (count),
    .ac_in    (ac_in),
    .mq_in    (mq_in),
    .ac_out   (ac_out),
    .mq_out   (mq_out),
    .step_out (step_out),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .flag_nv  (flag_nv),
    .busy     (busy),
    .done     (done)
);

// File: tb/sne_engine_tb_top.sv
module sne_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [5:0]  count = '0;
    logic [15:0] ac_in = '0;
    logic [15:0] mq_in = '0;
    logic [15:0] ac_out, mq_out;
    logic [5:0]  step_out;
    logic        flag_n, flag_v, flag_c, flag_nv, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [15:0] ac;
        logic [15:0] mq;
        logic [5:0]  sc;
        logic        n, v, c, nv;
        int          due;
        string       req;
    } exp_t;

    exp_t sbq[$];

    sne_engine #(.W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
        .ac_in(ac_in), .mq_in(mq_in), .ac_out(ac_out), .mq_out(mq_out),
        .step_out(step_out), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
        .flag_nv(flag_nv), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // Bit-serial reference built from the requirements.
    function automatic exp_t model(input logic [1:0] o, input logic [5:0] n,
                                   input logic [15:0] a, input logic [15:0] m,
                                   output int lat);
        exp_t e;
        logic [31:0] x, outs;
        logic vv, cc;
        int k;
        x = {a, m}; vv = 1'b0; cc = 1'b0; k = 0; lat = 1; outs = '0;
        if (o[1]) begin
            for (int i = 0; i < 31; i++) begin
                if ((x[31] != x[30]) || (x[31:16] == 16'hC000 && x[15:0] == 16'h0)) break;
                x = x << 1;
                k++;
            end
            lat = k + 2;
        end else if (n != 0 && n < 32) begin
            outs = {32{x[31]}};
            for (int i = 0; i < int'(n); i++) begin
                if (o[0]) begin
                    outs = {outs[30:0], x[30]};
                    x = {x[31], x[29:0], 1'b0};
                end else begin
                    outs = {outs[30:0], x[31]};
                    x = {x[30:0], 1'b0};
                end
            end
            vv = (outs != {32{x[31]}});
            cc = outs[0];
        end else if (n >= 32) begin
            for (int i = 0; i < 64 - int'(n); i++) begin
                cc = x[0];
                x = o[0] ? {x[31], x[31:1]} : {1'b0, x[31:1]};
            end
        end
        e.ac = x[31:16]; e.mq = x[15:0]; e.sc = 6'(k);
        e.v = vv; e.c = cc; e.n = x[31]; e.nv = vv ^ x[31];
        e.due = 0; e.req = "";
        return e;
    endfunction

    task automatic issue(input logic [1:0] o, input logic [5:0] n,
                         input logic [15:0] a, input logic [15:0] m, input string r);
        exp_t e;
        int lat;
        @(negedge clk);
        e = model(o, n, a, m, lat);
        e.due = cyc + lat;
        e.req = r;
        start = 1'b1; op = o; count = n; ac_in = a; mq_in = m;
        sbq.push_back(e);
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string r, input string act, input string expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", r, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every completion.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 unexpected done", "done=1", "done=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(ac_out == e.ac && mq_out == e.mq && step_out == e.sc &&
                      flag_n == e.n && flag_v == e.v && flag_c == e.c &&
                      flag_nv == e.nv && cyc == e.due,
                      e.req,
                      $sformatf("%h:%h sc=%0d nvc=%b%b%b nv=%b cyc=%0d", ac_out, mq_out,
                                step_out, flag_n, flag_v, flag_c, flag_nv, cyc),
                      $sformatf("%h:%h sc=%0d nvc=%b%b%b nv=%b cyc=%0d", e.ac, e.mq,
                                e.sc, e.n, e.v, e.c, e.nv, e.due));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9 watchdog", "no completion", "completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(ac_out == 0 && mq_out == 0 && step_out == 0 && !flag_n && !flag_v &&
              !flag_c && !flag_nv && !busy && !done, "R1 reset state",
              $sformatf("%h:%h sc=%0d busy=%b done=%b", ac_out, mq_out, step_out, busy, done),
              "0000:0000 sc=0 busy=0 done=0");

        issue(2'b00, 6'd0,  16'h8001, 16'h1234, "R2 zero count");
        issue(2'b01, 6'd0,  16'h0123, 16'hFFFF, "R2 zero count arith");
        issue(2'b00, 6'd4,  16'h0123, 16'h4567, "R3 lsh left 4");
        issue(2'b00, 6'd1,  16'h4000, 16'h0000, "R3 R6 lsh left overflow");
        issue(2'b00, 6'd31, 16'h0000, 16'h0001, "R3 lsh left 31");
        issue(2'b01, 6'd3,  16'h9000, 16'h0000, "R4 ash left keeps sign");
        issue(2'b01, 6'd2,  16'h2000, 16'h8001, "R4 ash left overflow");
        issue(2'b00, 6'd62, 16'h8000, 16'h0003, "R5 lsh right 2");
        issue(2'b01, 6'd62, 16'h8000, 16'h0003, "R5 ash right 2");
        issue(2'b00, 6'd32, 16'hFFFF, 16'hFFFF, "R5 lsh count 32");
        issue(2'b01, 6'd32, 16'h8000, 16'h0000, "R5 ash count 32 neg");
        issue(2'b01, 6'd32, 16'h7FFF, 16'hFFFF, "R5 ash count 32 pos");
        issue(2'b01, 6'd33, 16'hA5A5, 16'h5A5A, "R5 ash right 31");
        drain();

        issue(2'b10, 6'd0,  16'h0000, 16'h0001, "R7 normalize 30");
        drain();
        issue(2'b10, 6'd0,  16'h0000, 16'h0000, "R7 normalize limit 31");
        drain();
        issue(2'b10, 6'd5,  16'hE000, 16'h0000, "R7 R8 special stop");
        drain();
        issue(2'b11, 6'd0,  16'hE000, 16'h0001, "R7 R8 normalize neg");
        drain();
        issue(2'b10, 6'd0,  16'h4000, 16'h0000, "R9 normalize none");
        drain();

        // R10: start during a running normalize must be ignored.
        issue(2'b10, 6'd0, 16'h0000, 16'h0000, "R10 normalize with stray start");
        repeat (3) @(negedge clk);
        start = 1'b1; op = 2'b00; count = 6'd4; ac_in = 16'hFFFF; mq_in = 16'hFFFF;
        check(busy == 1'b1, "R10 busy during normalize", $sformatf("%b", busy), "1");
        @(posedge clk);
        #1 start = 1'b0;
        drain();

        // R9: back-to-back shifts, then a start in a normalize's done cycle.
        issue(2'b00, 6'd8, 16'h00FF, 16'h0F0F, "R9 back to back a");
        issue(2'b01, 6'd60, 16'hF0F0, 16'h1234, "R9 back to back b");
        drain();
        issue(2'b10, 6'd0, 16'h2000, 16'h0000, "R9 normalize 1");
        @(negedge clk);
        @(negedge clk);
        issue(2'b00, 6'd16, 16'h1111, 16'h2222, "R9 start in done cycle");
        drain();
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule